// File: doc/BRIEF.md
# Pad Interrupt Router with Sense Filter

This block watches a parameterised set of chip pad inputs and routes any of them onto eight interrupt channels that feed a downstream interrupt controller. That controller accepts only active-high levels and rising edges. Each channel therefore has its own pad selector, an optional input inversion, a level/edge choice and a stability filter. A source that is active low, or that signals on a falling edge, still reaches the controller in the one form it understands.

Every pad passes through a two-flop synchroniser. A channel picks one synchronised pad and optionally inverts it. The result then passes through a counter filter that ignores changes shorter than a programmed number of clocks. In level mode the filtered value is the channel output. In edge mode a rising transition of the filtered value produces a single-clock pulse. Software sets everything up through four 32-bit registers on a simple write-enable bus with combinational read data.

Top module: `pad_irq_router`

## Requirements
- R1: After reset every register reads zero and every interrupt output is low. Each channel then selects pad 0 in active-high level mode with no filter.
- R2: The bus decodes `bus_addr[3:2]` only when `bus_addr[1:0]` is zero. Writes to a misaligned address change nothing, and reads from one return zero. A write lands on the clock edge where `bus_we` is high, and `bus_rdata` shows the stored value from the next cycle.
- R3: Register word 0 (offset 0x00) has an edge-enable bit for channel c at bit c and an invert bit for channel c at bit 16+c. Its other bits read as zero.
- R4: Register words 1 and 2 (offsets 0x04 and 0x08) hold 8-bit pad selectors. Word 1 covers channels 0 to 3 and word 2 covers channels 4 to 7, with channel c at bit 8*(c mod 4). Register word 3 (offset 0x0C) holds a 4-bit filter length N for channel c at bit 4*c.
- R5: In level mode with N of 0 or 1, a pad change reaches the channel output after the third rising clock edge: two synchroniser stages, then the filter register. The output equals the pad value, inverted when the invert bit is set.
- R6: In edge mode with the invert bit clear, a rising edge on the selected pad gives an output pulse exactly one clock wide, in the same cycle a level output would have risen. A falling edge gives no pulse.
- R7: In edge mode with the invert bit set, a falling edge on the pad gives the one-clock pulse and a rising edge gives none.
- R8: With N of 2 or more, the filtered value takes a new input value only after that value has been seen on N consecutive clocks. A shorter excursion leaves the output unchanged. If N is lowered while a count is running, the change is taken as soon as the count reaches the new N.
- R9: A selector value at or above NUM_PADS drives a constant zero after the inversion stage, so that channel never asserts in any mode or polarity. Selector NUM_PADS-1 is still a valid pad.
- R10: Channels work independently of each other. Several channels may select the same pad with different modes and polarities.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable, sampled on the rising clock edge |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_i | input | NUM_PADS | Asynchronous pad inputs |
| irq_o | output | 8 | Channel outputs to the downstream controller, active high |

## Verification
The bench counts the clocks of pad-to-output latency through the synchroniser and the filter register. A design that dropped a synchroniser stage or added a register would report the level one cycle early or late. It checks that edge pulses last exactly one cycle and that the inverted edge mode reacts to the falling edge only. A wrong edge detector would either stretch the pulse into a level or fire on both edges. Glitches of N-1 clocks must be swallowed while N clocks pass. The first out-of-range selector, at the pad count, must stay silent even when inverted, while the last valid pad still routes. An off-by-one in that range check either leaks an asserted inverted zero or loses the top pad. Randomised register contents and pad activity are compared cycle by cycle against a bench model. Some channels share pads and filter lengths change mid-count, which catches crosstalk between channels and field-position errors in the register map.

// File: rtl/pirq_pkg.sv
`timescale 1ns/1ps
package pirq_pkg;
    localparam int NUM_CH  = 8;
    localparam int SEL_W   = 8;
    localparam int FLT_W   = 4;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int INV_POS = 16;

    typedef enum logic [1:0] {
        WORD_SENSE = 2'd0,
        WORD_SELLO = 2'd1,
        WORD_SELHI = 2'd2,
        WORD_FILT  = 2'd3
    } word_e;

    typedef struct packed {
        logic [NUM_CH-1:0]            edge_en;
        logic [NUM_CH-1:0]            inv;
        logic [NUM_CH-1:0][SEL_W-1:0] sel;
        logic [NUM_CH-1:0][FLT_W-1:0] flt;
    } cfg_t;
endpackage

// File: rtl/pirq_cfg_regs.sv
`timescale 1ns/1ps
module pirq_cfg_regs
    import pirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              we_i,
    output logic [DATA_W-1:0] rdata_o,
    output cfg_t              cfg_o
);
    localparam int HALF = NUM_CH / 2;

    cfg_t cfg_d, cfg_q;
    logic aligned;
    word_e word;

    assign aligned = (addr_i[1:0] == 2'b00);
    assign word    = word_e'(addr_i[ADDR_W-1:2]);

    always_comb begin
        cfg_d = cfg_q;
        if (we_i && aligned) begin
            unique case (word)
                WORD_SENSE: begin
                    cfg_d.edge_en = wdata_i[NUM_CH-1:0];
                    cfg_d.inv     = wdata_i[INV_POS +: NUM_CH];
                end
                WORD_SELLO: cfg_d.sel[HALF-1:0]      = wdata_i;
                WORD_SELHI: cfg_d.sel[NUM_CH-1:HALF] = wdata_i;
                WORD_FILT:  cfg_d.flt                = wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata_o = '0;
        if (aligned) begin
            unique case (word)
                WORD_SENSE: begin
                    rdata_o[NUM_CH-1:0]       = cfg_q.edge_en;
                    rdata_o[INV_POS +: NUM_CH] = cfg_q.inv;
                end
                WORD_SELLO: rdata_o = cfg_q.sel[HALF-1:0];
                WORD_SELHI: rdata_o = cfg_q.sel[NUM_CH-1:HALF];
                WORD_FILT:  rdata_o = cfg_q.flt;
                default: ;
            endcase
        end
    end

    assign cfg_o = cfg_q;

    // R3
    sense_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == '0) |=>
            (cfg_q.edge_en == $past(wdata_i[NUM_CH-1:0]) &&
             cfg_q.inv == $past(wdata_i[INV_POS +: NUM_CH])));

    // R2
    misaligned_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i[1:0] != 2'b00) |=> (cfg_q == $past(cfg_q)));
endmodule

// File: rtl/pirq_sync.sv
`timescale 1ns/1ps
module pirq_sync #(
    parameter int WIDTH = 133
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.meta   = async_i;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.stable;
endmodule

// File: rtl/pirq_channel.sv
`timescale 1ns/1ps
module pirq_channel
    import pirq_pkg::*;
#(
    parameter int NUM_PADS = 133
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PADS-1:0] pad_s_i,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic                inv_i,
    input  logic                edge_i,
    input  logic [FLT_W-1:0]    flt_i,
    output logic                irq_o
);
    localparam int               SPAN    = 1 << SEL_W;
    localparam logic [SEL_W:0]   PAD_LIM = (SEL_W + 1)'(NUM_PADS);
    localparam logic [FLT_W:0]   ONE     = (FLT_W + 1)'(1);

    typedef struct packed {
        logic             filt;
        logic             prev;
        logic [FLT_W-1:0] cnt;
    } chan_t;

    chan_t st_d, st_q;
    logic [SPAN-1:0] pad_ext;
    logic in_range;
    logic chan_in;

    for (genvar i = 0; i < SPAN; i++) begin : g_ext
        if (i < NUM_PADS) begin : g_pad
            assign pad_ext[i] = pad_s_i[i];
        end else begin : g_none
            assign pad_ext[i] = 1'b0;
        end
    end

    assign in_range = ({1'b0, sel_i} < PAD_LIM);
    assign chan_in  = in_range & (pad_ext[sel_i] ^ inv_i);

    always_comb begin
        st_d      = st_q;
        st_d.prev = st_q.filt;
        if (flt_i == '0) begin
            st_d.filt = chan_in;
            st_d.cnt  = '0;
        end else if (chan_in == st_q.filt) begin
            st_d.cnt = '0;
        end else if (({1'b0, st_q.cnt} + ONE) >= {1'b0, flt_i}) begin
            st_d.filt = chan_in;
            st_d.cnt  = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = edge_i ? (st_q.filt & ~st_q.prev) : st_q.filt;

    // R6
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && irq_o) |=> !(edge_i && irq_o));

    // R8
    filter_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.filt) |-> (st_q.filt == $past(chan_in)));

    // R9
    range_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!in_range) |-> !$rose(st_q.filt));
endmodule

// File: rtl/pad_irq_router.sv
`timescale 1ns/1ps
module pad_irq_router
    import pirq_pkg::*;
#(
    parameter int NUM_PADS = 133
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_we,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PADS-1:0] pad_i,
    output logic [NUM_CH-1:0]   irq_o
);
    cfg_t cfg;
    logic [NUM_PADS-1:0] pad_s;

    pirq_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .we_i    (bus_we),
        .rdata_o (bus_rdata),
        .cfg_o   (cfg)
    );

    pirq_sync #(.WIDTH(NUM_PADS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_i),
        .sync_o  (pad_s)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pirq_channel #(.NUM_PADS(NUM_PADS)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .pad_s_i (pad_s),
            .sel_i   (cfg.sel[c]),
            .inv_i   (cfg.inv[c]),
            .edge_i  (cfg.edge_en[c]),
            .flt_i   (cfg.flt[c]),
            .irq_o   (irq_o[c])
        );
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (irq_o == '0));
endmodule

// File: tb/pad_irq_router_test.sv
`timescale 1ns/1ps
module pad_irq_router_test;
    localparam int NP  = 133;
    localparam int NCH = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic [3:0]    addr;
    logic [31:0]   wdata;
    logic          we;
    logic [31:0]   rdata;
    logic [NP-1:0] pads;
    logic [NCH-1:0] irq;

    pad_irq_router #(.NUM_PADS(NP)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
        .bus_we(we), .bus_rdata(rdata), .pad_i(pads), .irq_o(irq)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;
    string cur_req = "R1";

    // mirror of the programmed configuration
    logic [7:0] m_edge, m_inv;
    logic [7:0] m_sel [NCH];
    logic [3:0] m_flt [NCH];
    // behavioural model state
    logic [NP-1:0] m_s1, m_s2;
    logic m_f [NCH];
    logic m_p [NCH];
    int   m_c [NCH];

    function automatic logic model_in(int c);
        int s = int'(m_sel[c]);
        if (s >= NP) return 1'b0;
        return m_s2[s] ^ m_inv[c];
    endfunction

    function automatic logic [NCH-1:0] exp_vec();
        logic [NCH-1:0] v;
        for (int c = 0; c < NCH; c++)
            v[c] = m_edge[c] ? (m_f[c] & ~m_p[c]) : m_f[c];
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_edge <= '0; m_inv <= '0; m_s1 <= '0; m_s2 <= '0;
            for (int c = 0; c < NCH; c++) begin
                m_sel[c] <= '0; m_flt[c] <= '0;
                m_f[c] <= 1'b0; m_p[c] <= 1'b0; m_c[c] <= 0;
            end
        end else begin
            if (we && addr[1:0] == 2'b00) begin
                case (addr[3:2])
                    2'd0: begin m_edge <= wdata[7:0]; m_inv <= wdata[23:16]; end
                    2'd1: for (int c = 0; c < 4; c++) m_sel[c] <= wdata[c*8 +: 8];
                    2'd2: for (int c = 0; c < 4; c++) m_sel[c+4] <= wdata[c*8 +: 8];
                    default: for (int c = 0; c < NCH; c++) m_flt[c] <= wdata[c*4 +: 4];
                endcase
            end
            m_s1 <= pads;
            m_s2 <= m_s1;
            for (int c = 0; c < NCH; c++) begin
                logic inp;
                inp = model_in(c);
                m_p[c] <= m_f[c];
                if (m_flt[c] == 4'd0) begin
                    m_f[c] <= inp; m_c[c] <= 0;
                end else if (inp == m_f[c]) begin
                    m_c[c] <= 0;
                end else if (m_c[c] + 1 >= int'(m_flt[c])) begin
                    m_f[c] <= inp; m_c[c] <= 0;
                end else begin
                    m_c[c] <= m_c[c] + 1;
                end
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        chk(cur_req, 32'(irq), 32'(exp_vec()));
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        tick();
        we = 1'b0; addr = 4'h0; wdata = '0;
    endtask

    task automatic rd_chk(string req, logic [3:0] a, logic [31:0] exp);
        addr = a;
        #1;
        chk(req, rdata, exp);
        addr = 4'h0;
    endtask

    task automatic clear_cfg();
        wr(4'h0, '0); wr(4'h4, '0); wr(4'h8, '0); wr(4'hC, '0);
        repeat (20) tick();
    endtask

    function automatic logic [7:0] pick_sel();
        int r = int'($urandom % 16);
        if (r < 10) return 8'(r);
        if (r < 13) return 8'(130 + r - 10);
        if (r == 13) return 8'(NP);
        return 8'(200 + r);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5eed));
        rst_n = 1'b0; pads = '0; we = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", 32'(irq), 32'h0);
        for (int a = 0; a < 4; a++) rd_chk("R1", 4'(a * 4), 32'h0);
        rst_n = 1'b1;
        repeat (4) tick();

        // R2, R3, R4 register map
        cur_req = "R2";
        wr(4'h0, 32'hFFFF_FFFF);
        rd_chk("R3", 4'h0, 32'h00FF_00FF);
        wr(4'h4, 32'h8485_0386);
        rd_chk("R4", 4'h4, 32'h8485_0386);
        wr(4'h8, 32'h0102_0304);
        rd_chk("R4", 4'h8, 32'h0102_0304);
        wr(4'hC, 32'h1234_5678);
        rd_chk("R4", 4'hC, 32'h1234_5678);
        wr(4'h5, 32'hDEAD_BEEF);
        rd_chk("R2", 4'h4, 32'h8485_0386);
        rd_chk("R2", 4'h5, 32'h0);
        clear_cfg();

        // R5 level latency, N = 0
        cur_req = "R5";
        wr(4'h4, 32'h0000_0005);
        repeat (4) tick();
        pads[5] = 1'b1;
        tick(); chk("R5", 32'(irq[0]), 0);
        tick(); chk("R5", 32'(irq[0]), 0);
        tick(); chk("R5", 32'(irq[0]), 1);
        pads[5] = 1'b0;
        repeat (2) tick(); chk("R5", 32'(irq[0]), 1);
        tick(); chk("R5", 32'(irq[0]), 0);

        // R6 rising edge pulse on channel 1
        cur_req = "R6";
        wr(4'h0, 32'h0000_0002);
        wr(4'h4, 32'h0000_0605);
        repeat (4) tick();
        pads[6] = 1'b1;
        tick(); tick(); chk("R6", 32'(irq[1]), 0);
        tick(); chk("R6", 32'(irq[1]), 1);
        tick(); chk("R6", 32'(irq[1]), 0);
        pads[6] = 1'b0;
        for (int i = 0; i < 5; i++) begin tick(); chk("R6", 32'(irq[1]), 0); end

        // R7 falling edge pulse via inversion
        cur_req = "R7";
        wr(4'h0, 32'h0002_0002);
        repeat (6) tick();
        pads[6] = 1'b1;
        for (int i = 0; i < 5; i++) begin tick(); chk("R7", 32'(irq[1]), 0); end
        pads[6] = 1'b0;
        tick(); tick(); chk("R7", 32'(irq[1]), 0);
        tick(); chk("R7", 32'(irq[1]), 1);
        tick(); chk("R7", 32'(irq[1]), 0);
        clear_cfg();

        // R8 filter of length 4 on channel 2, pad 7
        cur_req = "R8";
        wr(4'h4, 32'h0007_0000);
        wr(4'hC, 32'h0000_0400);
        repeat (4) tick();
        pads[7] = 1'b1;
        repeat (3) tick();
        pads[7] = 1'b0;
        for (int i = 0; i < 8; i++) begin tick(); chk("R8", 32'(irq[2]), 0); end
        pads[7] = 1'b1;
        repeat (5) tick(); chk("R8", 32'(irq[2]), 0);
        tick(); chk("R8", 32'(irq[2]), 1);
        pads[7] = 1'b0;
        clear_cfg();

        // R9 out-of-range selectors stay silent, last pad still routes
        cur_req = "R9";
        wr(4'h0, 32'h0008_0000);
        wr(4'h4, 32'hC800_0000);
        for (int i = 0; i < 8; i++) begin
            pads = ~pads; tick(); chk("R9", 32'(irq[3]), 0);
        end
        wr(4'h4, 32'(NP) << 24);
        for (int i = 0; i < 6; i++) begin tick(); chk("R9", 32'(irq[3]), 0); end
        pads = '0;
        wr(4'h4, 32'(NP - 1) << 24);
        repeat (4) tick(); chk("R9", 32'(irq[3]), 1);
        clear_cfg();

        // R10 two channels on one pad, opposite polarity
        cur_req = "R10";
        wr(4'h8, 32'h0000_0505);
        wr(4'h0, 32'h0020_0000);
        pads[5] = 1'b1;
        repeat (4) tick(); chk("R10", 32'(irq[5:4]), 32'h1);
        pads[5] = 1'b0;
        repeat (4) tick(); chk("R10", 32'(irq[5:4]), 32'h2);
        clear_cfg();

        // R10 randomised configuration and pad activity against the model
        cur_req = "R10";
        for (int ph = 0; ph < 12; ph++) begin
            logic [31:0] s0, s1;
            wr(4'h0, $urandom & 32'h00FF_00FF);
            s0 = {pick_sel(), pick_sel(), pick_sel(), pick_sel()};
            s1 = {pick_sel(), pick_sel(), pick_sel(), pick_sel()};
            wr(4'h4, s0);
            wr(4'h8, s1);
            wr(4'hC, $urandom & 32'h3333_3333 | ((ph % 3 == 0) ? 32'h8000_0000 : 32'h0));
            for (int cy = 0; cy < 1500; cy++) begin
                for (int p = 0; p < 10; p++)
                    if ($urandom % 6 == 0) pads[p] = ~pads[p];
                for (int p = 130; p < NP; p++)
                    if ($urandom % 6 == 0) pads[p] = ~pads[p];
                if (cy == 700) wr(4'hC, $urandom & 32'h7777_7777);
                else tick();
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule